// File: doc/BRIEF.md
# FIFO-Buffered Sequential RAM Writer

This block takes a stream of small data words from a producer and stores them, in arrival order, into an on-chip register-array RAM. The producer never supplies an address: it pushes words into a synchronous first-in first-out queue. The queue drains one word per cycle into the RAM, and an internal address counter starts at zero and steps by one after each stored word. The RAM therefore fills as a linear log of everything the producer sent.

When the last RAM location has been written, a log-full flag rises and draining stops. Words the producer sends after that point collect in the queue until it reports full. The producer must watch the queue-full flag and hold off while it is high; a push made while the flag is high is rejected. A separate readback port reads any RAM word with one cycle of latency. It exists so that the stored log can be inspected.

The asynchronous active-low reset is released through a two-stage synchronizer. The block therefore leaves reset on the second rising clock edge after the reset pin goes high.

Top module: `rlog_writer`

## Requirements
- R1: While reset is held and after its release, `in_full` and `log_full` are 0, `rb_data` is 0 and the next word is stored at address 0.
- R2: Each word accepted on a rising edge with `in_wr` high is written into the RAM on the following rising edge. The RAM address is 0 for the first word after reset and rises by one for each later word, so word k lands at address k.
- R3: Words pushed on consecutive cycles are stored at one word per cycle. While the RAM is not full, `in_full` stays 0.
- R4: `log_full` rises on the edge that writes address RAM_WORDS-1. From then on the RAM is not written, and earlier contents, including address 0, are kept.
- R5: Once `log_full` is 1, pushed words are held in the queue. `in_full` is 1 exactly when the queue holds FIFO_WORDS words, and a push while `in_full` is 1 is discarded.
- R6: A rising edge with `rb_en` high loads `rb_data` with the word at `rb_addr`. While `rb_en` is 0, `rb_data` keeps its value.
- R7: `log_full` stays 1 until reset. After reset, storing restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DW | Producer data word |
| in_wr | input | 1 | Producer push request |
| in_full | output | 1 | Queue holds FIFO_WORDS words; pushes are rejected |
| log_full | output | 1 | Last RAM address has been written |
| rb_en | input | 1 | Readback enable |
| rb_addr | input | $clog2(RAM_WORDS) | Readback address |
| rb_data | output | DW | Registered readback word |

## Verification
The bench builds the block with a 16-word RAM of 4-bit words and a 4-word queue. In that size one run can write every RAM address and read each one back. The same run reaches the end-of-log boundary, the switch from drain to hold, a completely filled queue and a rejected push. Expected RAM contents come from a simple arithmetic formula of the push index, so every address is checked against a value the bench computes itself.

// File: rtl/rlog_pkg.sv
package rlog_pkg;
  parameter int unsigned DEF_DW         = 4;
  parameter int unsigned DEF_RAM_WORDS  = 256;
  parameter int unsigned DEF_FIFO_WORDS = 16;
endpackage

// File: rtl/rlog_rst_sync.sv
module rlog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rlog_fifo.sv
module rlog_fifo #(
  parameter int unsigned DW    = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW:0]   wr_ptr_q, wr_ptr_d;
  logic [AW:0]   rd_ptr_q, rd_ptr_d;
  logic          push_ok, pop_ok;
  logic [DW-1:0] mem_q [DEPTH];

  assign full    = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign empty   = (wr_ptr_q == rd_ptr_q);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem_q[rd_ptr_q[AW-1:0]];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wr_ptr_q[AW-1:0] == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) mem_q[g] <= push_data;
    end
  end
endmodule

// File: rtl/rlog_seq.sv
module rlog_seq #(
  parameter int unsigned WORDS = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     avail,
  output logic                     take,
  output logic [$clog2(WORDS)-1:0] addr,
  output logic                     done
);
  localparam int unsigned AW   = $clog2(WORDS);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;

  assign take = avail && !done_q;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (take) begin
      addr_d = AW'(addr_q + 1'b1);
      if (addr_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr = addr_q;
  assign done = done_q;
endmodule

// File: rtl/rlog_ram.sv
module rlog_ram #(
  parameter int unsigned DW    = 4,
  parameter int unsigned WORDS = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  localparam int unsigned AW = $clog2(WORDS);

  logic [DW-1:0] cell_q [WORDS];
  logic [DW-1:0] rdata_q, rdata_d;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic word_we;
    assign word_we = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (word_we) cell_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = cell_q[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rlog_writer.sv
module rlog_writer #(
  parameter int unsigned DW         = rlog_pkg::DEF_DW,
  parameter int unsigned RAM_WORDS  = rlog_pkg::DEF_RAM_WORDS,
  parameter int unsigned FIFO_WORDS = rlog_pkg::DEF_FIFO_WORDS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                in_data,
  input  logic                         in_wr,
  output logic                         in_full,
  output logic                         log_full,
  input  logic                         rb_en,
  input  logic [$clog2(RAM_WORDS)-1:0] rb_addr,
  output logic [DW-1:0]                rb_data
);
  localparam int unsigned AW = $clog2(RAM_WORDS);

  logic          rst_sn;
  logic          fifo_empty;
  logic          ram_we;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] head_data;

  rlog_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rlog_fifo #(.DW(DW), .DEPTH(FIFO_WORDS)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sn),
    .push      (in_wr),
    .push_data (in_data),
    .pop       (ram_we),
    .head      (head_data),
    .full      (in_full),
    .empty     (fifo_empty)
  );

  rlog_seq #(.WORDS(RAM_WORDS)) u_seq (
    .clk   (clk),
    .rst_n (rst_sn),
    .avail (!fifo_empty),
    .take  (ram_we),
    .addr  (wr_addr),
    .done  (log_full)
  );

  rlog_ram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (ram_we),
    .waddr (wr_addr),
    .wdata (head_data),
    .re    (rb_en),
    .raddr (rb_addr),
    .rdata (rb_data)
  );
endmodule

// File: rtl/rlog_writer_chk.sv
module rlog_writer_chk #(
  parameter int unsigned DW    = 4,
  parameter int unsigned WORDS = 256
) (
  input logic                     clk,
  input logic                     rst_sn,
  input logic                     ram_we,
  input logic [$clog2(WORDS)-1:0] wr_addr,
  input logic                     fifo_empty,
  input logic                     log_full,
  input logic                     in_full,
  input logic                     rb_en,
  input logic [DW-1:0]            rb_data
);
  localparam int unsigned AW = $clog2(WORDS);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ram_we |=> (log_full || wr_addr == AW'($past(wr_addr) + 1'b1)));

  // R2
  we_has_data_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ram_we |-> !fifo_empty);

  // R4
  no_write_after_full_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    log_full |-> !ram_we);

  // R4
  full_at_end_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(log_full) |-> ($past(ram_we) && $past(wr_addr) == AW'(WORDS - 1)));

  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    log_full |=> log_full);

  // R5
  fifo_stall_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    in_full |-> log_full);

  // R6
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !rb_en |=> $stable(rb_data));
endmodule

bind rlog_writer rlog_writer_chk #(.DW(DW), .WORDS(RAM_WORDS)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .ram_we     (ram_we),
  .wr_addr    (wr_addr),
  .fifo_empty (fifo_empty),
  .log_full   (log_full),
  .in_full    (in_full),
  .rb_en      (rb_en),
  .rb_data    (rb_data)
);

// File: tb/sim_rlog_writer.sv
`timescale 1ns/1ps
module sim_rlog_writer;
  localparam int DW = 4;
  localparam int RW = 16;
  localparam int FW = 4;
  localparam int AW = $clog2(RW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_wr = 1'b0;
  logic          in_full, log_full;
  logic          rb_en = 1'b0;
  logic [AW-1:0] rb_addr = '0;
  logic [DW-1:0] rb_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rlog_writer #(.DW(DW), .RAM_WORDS(RW), .FIFO_WORDS(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_wr(in_wr),
    .in_full(in_full), .log_full(log_full),
    .rb_en(rb_en), .rb_addr(rb_addr), .rb_data(rb_data)
  );

  function automatic logic [DW-1:0] word_of(int i);
    return DW'((i * 7 + 3) % 16);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic [DW-1:0] d);
    in_wr   = 1'b1;
    in_data = d;
    @(negedge clk);
    in_wr   = 1'b0;
  endtask

  task automatic readback(int a, output logic [DW-1:0] v);
    rb_en   = 1'b1;
    rb_addr = AW'(a);
    @(negedge clk);
    rb_en   = 1'b0;
    v       = rb_data;
  endtask

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 in_full", int'(in_full), 0);
    check("R1 log_full", int'(log_full), 0);
    check("R1 rb_data", int'(rb_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: words with idle gaps
    for (int i = 0; i < 5; i++) begin
      push(word_of(i));
      repeat (i % 3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      readback(a, v);
      check("R2 sequential store", int'(v), int'(word_of(a)));
    end
    check("R2 log_full low", int'(log_full), 0);

    // R3: back-to-back burst fills the rest
    for (int i = 5; i < RW; i++) begin
      push(word_of(i));
      check("R3 in_full low during burst", int'(in_full), 0);
    end
    @(negedge clk);
    // R4: flag raised after the last address is written
    check("R4 log_full", int'(log_full), 1);
    for (int a = 0; a < RW; a++) begin
      readback(a, v);
      check("R4 full sweep", int'(v), int'(word_of(a)));
    end

    // R5: queue fills, then rejects
    for (int i = RW; i < RW + FW; i++) begin
      check("R5 in_full before fill", int'(in_full), 0);
      push(word_of(i));
    end
    check("R5 in_full", int'(in_full), 1);
    push(word_of(RW + FW));
    check("R5 in_full after reject", int'(in_full), 1);
    repeat (3) @(negedge clk);
    // R7 sticky, R4 no overwrite
    check("R7 log_full sticky", int'(log_full), 1);
    readback(0, v);
    check("R4 addr0 kept", int'(v), int'(word_of(0)));
    readback(RW - 1, v);
    check("R4 last kept", int'(v), int'(word_of(RW - 1)));

    // R6: hold when rb_en low
    held = rb_data;
    rb_addr = '0;
    repeat (4) @(negedge clk);
    check("R6 hold", int'(rb_data), int'(held));

    // R7: reset restarts at address 0
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 in_full after reset", int'(in_full), 0);
    check("R7 log_full cleared", int'(log_full), 0);
    check("R1 rb_data cleared", int'(rb_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push(4'hA);
    push(4'h5);
    repeat (2) @(negedge clk);
    readback(0, v);
    check("R7 restart addr0", int'(v), 10);
    readback(1, v);
    check("R7 restart addr1", int'(v), 5);
    readback(2, v);
    check("R7 addr2 untouched", int'(v), int'(word_of(2)));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule